// File: doc/BRIEF.md
# Sized Integer Execute Unit with Condition Codes

This block is the integer execute stage of a 32-bit register machine. It takes a source operand, a destination operand, the current condition flags, an operation code and an operand size. It returns the value to write back into the destination register and the new five-bit condition code. The operations are add, subtract, address-add, unsigned 16x16 multiply, unsigned 32/16 divide and half-word swap. For byte and word add or subtract, only the low 8 or 16 bits of the destination are replaced. The upper bits pass through unchanged, so the register file can always write the full 32 bits.

An operation starts with a one-cycle `start` pulse. Every operation except a normal divide is registered on the `start` edge, and `done` pulses in the following cycle. A divide whose divisor is zero, or whose quotient would not fit in 16 bits, also finishes in one cycle. Any other divide runs a restoring, one-bit-per-cycle sequence and asserts `busy` until it finishes. A `start` that arrives while `busy` is high is ignored.

Top module: `sized_alu`

## Requirements
- R1: After reset, `result`, `flags`, `done`, `busy` and `divZero` are all zero. Op codes: 0 add, 1 subtract, 2 address-add, 3 multiply, 4 divide, 5 swap. Size codes: 0 byte, 1 word, 2 or 3 long. Any operation other than a normal divide raises `done` for exactly one cycle, one clock after `start`, and `busy` stays low.
- R2: A byte or word add or subtract replaces only bits 7:0 or 15:0 of `dst`. All other bits of `result` equal those of `dst`.
- R3: `flags` is {X,N,Z,V,C} in bits 4 down to 0. On add, C is the carry out of the selected size, X equals C, N is the top bit of the sized result, Z is set when the sized result is zero, and V is set when both operands have the same sign and the result sign differs from it.
- R4: Subtract computes dst minus src at the selected size. C (and X) is the borrow. V is set when the operand signs differ and the result sign differs from the sign of dst. N and Z follow the sized result.
- R5: Address-add with word (or byte) size sign-extends src[15:0] to 32 bits. With long size it uses all of src. It writes the full 32-bit sum, and `flags` equals `flagsIn`.
- R6: Multiply writes src[15:0] times dst[15:0] as a 32-bit unsigned product. N and Z follow bit 31 and zero. V=C=0, and X is unchanged.
- R7: Divide with a nonzero divisor and a quotient that fits in 16 bits writes the remainder to bits 31:16 and the quotient to bits 15:0. N and Z follow the 16-bit quotient, V=C=0 and X is unchanged. `done` comes 18 clocks after `start`, and `busy` is high in between.
- R8: Divide with src[15:0]=0 raises `divZero` together with `done`, one clock after `start`. `result` equals `dst` and `flags` equals `flagsIn`.
- R9: Divide whose quotient exceeds 16 bits finishes in one clock with V=1 and C=0. X, N and Z are unchanged, `result` equals `dst`, and `divZero` is 0.
- R10: Swap exchanges dst[31:16] and dst[15:0]. N and Z follow the 32-bit result, V=C=0 and X is unchanged.
- R11: A `start` pulse while `busy` is high has no effect: the running divide's result and timing are unchanged, and no extra `done` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op | input | 3 | Operation code |
| size | input | 2 | Operand size code |
| src | input | 32 | Source operand |
| dst | input | 32 | Destination operand (dividend for divide) |
| flagsIn | input | 5 | Current flags {X,N,Z,V,C} |
| result | output | 32 | Merged destination value, held until next completion |
| flags | output | 5 | New flags {X,N,Z,V,C} |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | A multi-cycle divide is in progress |
| divZero | output | 1 | Divide by zero, valid with done |

## Verification
The bench targets the size boundaries of add and subtract. These include byte 55h+78h and FFh+01h, word and long carries, and a borrow from zero. A unit that merged at the wrong width would corrupt the upper destination bits, and one that took carry or sign from bit 31 would report wrong C, V or N. Address-add with a negative word checks the sign extension, and a mismatch in the flags shows any flag leak. Divide is run on a normal case, on a quotient of exactly FFFFh, on a zero divisor and on a quotient overflow, so a wrong fast-exit test would either stall for 18 cycles or overwrite the destination. A `start` pulsed in the middle of a divide would, if accepted, produce an early `done` or a wrong quotient.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADDR = 3'd2,
    OP_MUL  = 3'd3,
    OP_DIV  = 3'd4,
    OP_SWAP = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_LONG3 = 2'd3
  } aluSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadOut;  // capture single-cycle result
    logic divInit;  // load divider working registers
    logic divStep;  // one restoring step
    logic divFin;   // capture divider result
  } aluCtrl_t;

  localparam int FLAG_W = 5;
  localparam int FX = 4;
  localparam int FN = 3;
  localparam int FZ = 2;
  localparam int FV = 1;
  localparam int FC = 0;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     isDiv,
  input  logic     divFast,
  output aluCtrl_t ctl,
  output logic     busy
);
  localparam int HW = DATA_W / 2;
  localparam int CW = $clog2(HW);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FIN} state_e;

  state_e        state;
  logic [CW-1:0] stepCnt;

  always_comb begin
    ctl = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (isDiv && !divFast) ctl.divInit = 1'b1;
          else                   ctl.loadOut = 1'b1;
        end
      end
      ST_RUN:  ctl.divStep = 1'b1;
      ST_FIN:  ctl.divFin  = 1'b1;
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start && isDiv && !divFast) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CW'(HW - 1)) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/alu_dp.sv
module alu_dp
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtrl_t          ctl,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic              divFast,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags,
  output logic              divZero,
  output logic              done
);
  localparam int DW = DATA_W;
  localparam int HW = DATA_W / 2;
  localparam int BW = 8;
  localparam int IW = $clog2(DW + 1);

  aluOp_e   opE;
  aluSize_e sizeE;
  assign opE   = aluOp_e'(op);
  assign sizeE = aluSize_e'(size);

  // ---------------- single-cycle arithmetic ----------------
  logic [DW-1:0]     mask;
  logic [IW-1:0]     topIdx;
  logic [IW-1:0]     carryIdx;
  logic [DW:0]       aM, bM, sum;
  logic [DW-1:0]     sumLo, extSrc, prod, swapped, nextRes;
  logic              cOut, vOut, aSign, bSign, rSign;
  logic              dz, ovf;
  logic [FLAG_W-1:0] nextFlags;

  always_comb begin
    case (sizeE)
      SZ_BYTE: begin
        mask     = {{(DW-BW){1'b0}}, {BW{1'b1}}};
        topIdx   = IW'(BW - 1);
        carryIdx = IW'(BW);
      end
      SZ_WORD: begin
        mask     = {{(DW-HW){1'b0}}, {HW{1'b1}}};
        topIdx   = IW'(HW - 1);
        carryIdx = IW'(HW);
      end
      default: begin
        mask     = {DW{1'b1}};
        topIdx   = IW'(DW - 1);
        carryIdx = IW'(DW);
      end
    endcase
  end

  always_comb begin
    aM    = {1'b0, dst & mask};
    bM    = {1'b0, src & mask};
    sum   = (opE == OP_SUB) ? (aM - bM) : (aM + bM);
    sumLo = sum[DW-1:0] & mask;
    cOut  = sum[carryIdx];
    rSign = sum[topIdx];
    aSign = aM[topIdx];
    bSign = bM[topIdx];
    if (opE == OP_SUB) vOut = (aSign != bSign) && (rSign != aSign);
    else               vOut = (aSign == bSign) && (rSign != aSign);
  end

  assign extSrc  = (sizeE == SZ_LONG || sizeE == SZ_LONG3) ? src
                   : {{(DW-HW){src[HW-1]}}, src[HW-1:0]};
  assign prod    = DW'(src[HW-1:0]) * DW'(dst[HW-1:0]);
  assign swapped = {dst[HW-1:0], dst[DW-1:HW]};
  assign dz      = (src[HW-1:0] == '0);
  assign ovf     = !dz && (dst[DW-1:HW] >= src[HW-1:0]);
  assign divFast = dz || ovf;

  always_comb begin
    case (opE)
      OP_ADD, OP_SUB: begin
        nextRes   = (dst & ~mask) | sumLo;
        nextFlags = {cOut, rSign, (sumLo == '0), vOut, cOut};
      end
      OP_ADDR: begin
        nextRes   = dst + extSrc;
        nextFlags = flagsIn;
      end
      OP_MUL: begin
        nextRes   = prod;
        nextFlags = {flagsIn[FX], prod[DW-1], (prod == '0), 1'b0, 1'b0};
      end
      OP_DIV: begin
        nextRes   = dst;
        nextFlags = dz ? flagsIn : {flagsIn[FX:FZ], 1'b1, 1'b0};
      end
      OP_SWAP: begin
        nextRes   = swapped;
        nextFlags = {flagsIn[FX], swapped[DW-1], (swapped == '0), 1'b0, 1'b0};
      end
      default: begin
        nextRes   = dst;
        nextFlags = flagsIn;
      end
    endcase
  end

  // ---------------- restoring divider ----------------
  logic [HW-1:0] divisorQ, remQ, quoQ;
  logic          xHoldQ;
  logic [HW:0]   trial;
  logic          fits;

  assign trial = {remQ, quoQ[HW-1]};
  assign fits  = (trial >= {1'b0, divisorQ});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divisorQ <= '0;
      remQ     <= '0;
      quoQ     <= '0;
      xHoldQ   <= 1'b0;
    end else if (ctl.divInit) begin
      divisorQ <= src[HW-1:0];
      remQ     <= dst[DW-1:HW];
      quoQ     <= dst[HW-1:0];
      xHoldQ   <= flagsIn[FX];
    end else if (ctl.divStep) begin
      remQ <= fits ? HW'(trial - {1'b0, divisorQ}) : trial[HW-1:0];
      quoQ <= {quoQ[HW-2:0], fits};
    end
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      result  <= '0;
      flags   <= '0;
      divZero <= 1'b0;
      done    <= 1'b0;
    end else if (ctl.loadOut) begin
      result  <= nextRes;
      flags   <= nextFlags;
      divZero <= (opE == OP_DIV) && dz;
      done    <= 1'b1;
    end else if (ctl.divFin) begin
      result  <= {remQ, quoQ};
      flags   <= {xHoldQ, quoQ[HW-1], (quoQ == '0), 1'b0, 1'b0};
      divZero <= 1'b0;
      done    <= 1'b1;
    end else begin
      divZero <= 1'b0;
      done    <= 1'b0;
    end
  end
endmodule

// File: rtl/sized_alu.sv
module sized_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic [4:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic [4:0]        flags,
  output logic              done,
  output logic              busy,
  output logic              divZero
);
  aluCtrl_t ctl;
  logic     divFast;
  logic     isDiv;

  assign isDiv = (op == OP_DIV);

  alu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .isDiv   (isDiv),
    .divFast (divFast),
    .ctl     (ctl),
    .busy    (busy)
  );

  alu_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .op      (op),
    .size    (size),
    .src     (src),
    .dst     (dst),
    .flagsIn (flagsIn),
    .divFast (divFast),
    .result  (result),
    .flags   (flags),
    .divZero (divZero),
    .done    (done)
  );
endmodule

// File: rtl/sized_alu_chk.sv
module sized_alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [2:0]        op,
  input logic [1:0]        size,
  input logic [DATA_W-1:0] src,
  input logic [DATA_W-1:0] dst,
  input logic [4:0]        flagsIn,
  input logic [DATA_W-1:0] result,
  input logic [4:0]        flags,
  input logic              done,
  input logic              busy,
  input logic              divZero
);
  localparam int HW = DATA_W / 2;

  logic accept;
  assign accept = start && !busy;

  AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    accept && (op != OP_DIV) |=> done && !busy);  // R1

  AST_BYTE_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    accept && (op == OP_ADD || op == OP_SUB) && (size == SZ_BYTE)
      |=> result[DATA_W-1:8] == $past(dst[DATA_W-1:8]));  // R2

  AST_X_FOLLOWS_C: assert property (@(posedge clk) disable iff (!rstN)
    accept && (op == OP_ADD || op == OP_SUB) |=> flags[FX] == flags[FC]);  // R3

  AST_ADDR_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    accept && (op == OP_ADDR) |=> flags == $past(flagsIn));  // R5

  AST_MUL_VC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    accept && (op == OP_MUL) |=> flags[FV:FC] == 2'b00);  // R6

  AST_DIVZERO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    accept && (op == OP_DIV) && (src[HW-1:0] == '0)
      |=> divZero && done && result == $past(dst));  // R8

  AST_DIVZERO_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    divZero |-> done);  // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);  // R11
endmodule

bind sized_alu sized_alu_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sized_alu_tb.sv
`timescale 1ns/1ps
module sized_alu_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [1:0]  size = '0;
  logic [31:0] src = '0;
  logic [31:0] dst = '0;
  logic [4:0]  flagsIn = '0;
  logic [31:0] result;
  logic [4:0]  flags;
  logic        done, busy, divZero;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sized_alu u_dut (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .size(size),
    .src(src), .dst(dst), .flagsIn(flagsIn), .result(result),
    .flags(flags), .done(done), .busy(busy), .divZero(divZero)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  task automatic model(input logic [2:0] o, input logic [1:0] sz, input logic [31:0] s,
                       input logic [31:0] d, input logic [4:0] fi,
                       output logic [31:0] er, output logic [4:0] ef,
                       output bit edz, output int lat);
    int bits;
    longint unsigned m, a, b, r, c, sa, sb, sr, v, q, rm, dv, ext;
    bits = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (64'd1 << bits) - 1;
    a = {32'd0, d} & m;
    b = {32'd0, s} & m;
    edz = 0; lat = 1; er = d; ef = fi;
    case (o)
      3'd0, 3'd1: begin
        if (o == 3'd0) begin r = a + b; c = (r >> bits) & 1; end
        else           begin r = a - b; c = (a < b) ? 1 : 0; end
        r = r & m;
        sa = (a >> (bits-1)) & 1; sb = (b >> (bits-1)) & 1; sr = (r >> (bits-1)) & 1;
        if (o == 3'd0) v = (sa == sb && sr != sa) ? 1 : 0;
        else           v = (sa != sb && sr != sa) ? 1 : 0;
        er = 32'(({32'd0, d} & ~m) | r);
        ef = {c[0], sr[0], (r == 0), v[0], c[0]};
      end
      3'd2: begin
        if (bits == 32) ext = {32'd0, s};
        else ext = (s[15]) ? ({32'd0, s} | 64'hFFFF0000) & 64'hFFFFFFFF : ({32'd0, s} & 64'hFFFF);
        er = 32'({32'd0, d} + ext);
        ef = fi;
      end
      3'd3: begin
        r = ({32'd0, s} & 64'hFFFF) * ({32'd0, d} & 64'hFFFF);
        er = 32'(r);
        ef = {fi[4], er[31], (er == 0), 1'b0, 1'b0};
      end
      3'd4: begin
        dv = {32'd0, s} & 64'hFFFF;
        if (dv == 0) begin edz = 1; end
        else begin
          q = {32'd0, d} / dv; rm = {32'd0, d} % dv;
          if (q > 64'hFFFF) ef = {fi[4:2], 1'b1, 1'b0};
          else begin
            er = 32'((rm << 16) | q);
            ef = {fi[4], q[15], (q == 0), 1'b0, 1'b0};
            lat = 18;
          end
        end
      end
      3'd5: begin
        er = {d[15:0], d[31:16]};
        ef = {fi[4], er[31], (er == 0), 1'b0, 1'b0};
      end
      default: ;
    endcase
  endtask

  // run one operation, comparing done/busy on every clock; pokeAt>0 pulses a stray start
  task automatic runOp(input logic [2:0] o, input logic [1:0] sz, input logic [31:0] s,
                       input logic [31:0] d, input logic [4:0] fi, input string tag,
                       input int pokeAt);
    logic [31:0] er; logic [4:0] ef; bit edz; int lat; bit tOk;
    model(o, sz, s, d, fi, er, ef, edz, lat);
    op = o; size = sz; src = s; dst = d; flagsIn = fi; start = 1'b1;
    tOk = 1;
    for (int cnt = 1; cnt <= lat; cnt++) begin
      @(posedge clk); #1;
      start = 1'b0;
      op = o;
      if (done !== (cnt == lat)) tOk = 0;
      if (cnt < lat && busy !== (lat > 1)) tOk = 0;
      if (pokeAt > 0 && cnt == pokeAt) begin start = 1'b1; op = 3'd0; end
    end
    chk(tOk, {tag, " timing"}, 32'(done), 32'(1));
    chk(result === er, {tag, " result"}, result, er);
    chk(flags === ef, {tag, " flags"}, 32'(flags), 32'(ef));
    chk(divZero === edz, {tag, " divZero"}, 32'(divZero), 32'(edz));
    @(posedge clk); #1;
    chk(done === 1'b0 && busy === 1'b0, {tag, " idle after"}, 32'({done, busy}), 32'(0));
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(result === 0 && flags === 0 && done === 0 && busy === 0 && divZero === 0,
        "R1 reset state", {result[26:0], flags}, 0);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R3 add at three sizes, R2 merging
    runOp(3'd0, 2'd0, 32'h12345678, 32'h22334455, 5'b00000, "R2 R3 add byte overflow", 0);
    runOp(3'd0, 2'd1, 32'h12345678, 32'h22334455, 5'b00000, "R2 R3 add word overflow", 0);
    runOp(3'd0, 2'd2, 32'h12345678, 32'h22334455, 5'b11111, "R3 add long clean", 0);
    runOp(3'd0, 2'd0, 32'h00000001, 32'hA5A5A5FF, 5'b00000, "R3 add byte carry zero", 0);
    runOp(3'd0, 2'd2, 32'h00000001, 32'hFFFFFFFF, 5'b00000, "R3 add long carry", 0);
    // R4 subtract
    runOp(3'd1, 2'd0, 32'h00000001, 32'hCAFE1200, 5'b00000, "R4 R2 sub byte borrow", 0);
    runOp(3'd1, 2'd2, 32'h00000001, 32'h80000000, 5'b00000, "R4 sub long overflow", 0);
    runOp(3'd1, 2'd1, 32'h00001234, 32'hFFFF1234, 5'b11111, "R4 sub word zero", 0);
    // R5 address add
    runOp(3'd2, 2'd1, 32'h2C34C11C, 32'h0112B33C, 5'b10101, "R5 addr word negative", 0);
    runOp(3'd2, 2'd2, 32'h2C34C11C, 32'h0112B33C, 5'b01010, "R5 addr long", 0);
    runOp(3'd2, 2'd0, 32'h00000070, 32'h00001000, 5'b00011, "R5 addr byte as word", 0);
    // R6 multiply
    runOp(3'd3, 2'd1, 32'h1234A678, 32'hA0120002, 5'b10011, "R6 mul small", 0);
    runOp(3'd3, 2'd1, 32'h336B4105, 32'hB11CA024, 5'b00011, "R6 mul large", 0);
    runOp(3'd3, 2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'b00000, "R6 mul max", 0);
    // R7 divide
    runOp(3'd4, 2'd1, 32'h1C32A024, 32'h28AC44B5, 5'b10000, "R7 div normal", 0);
    runOp(3'd4, 2'd1, 32'h00000002, 32'h0001FFFF, 5'b00000, "R7 div max quotient", 0);
    runOp(3'd4, 2'd1, 32'h0000FFFF, 32'h00000005, 5'b00001, "R7 div zero quotient", 0);
    // R8 divide by zero
    runOp(3'd4, 2'd1, 32'hFFFF0000, 32'h12345678, 5'b10101, "R8 div by zero", 0);
    // R9 quotient overflow
    runOp(3'd4, 2'd1, 32'h00000001, 32'h00100000, 5'b11100, "R9 div overflow", 0);
    runOp(3'd4, 2'd1, 32'h00001000, 32'h10000000, 5'b00000, "R9 div overflow equal", 0);
    // R10 swap
    runOp(3'd5, 2'd2, 32'h00000000, 32'h12345678, 5'b10011, "R10 swap", 0);
    runOp(3'd5, 2'd2, 32'h00000000, 32'h00000000, 5'b00000, "R10 swap zero", 0);
    runOp(3'd5, 2'd2, 32'h00000000, 32'h0000ABCD, 5'b00000, "R10 swap negative", 0);
    // R11 start while busy ignored
    runOp(3'd4, 2'd1, 32'h00000007, 32'h00012345, 5'b00000, "R11 start during divide", 4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule